// File: doc/BRIEF.md
# Extended-Group Shift Executor

This unit carries out the three byte shifts of the second-page opcode group of a small 8-bit processor: shift left with a zero fill, arithmetic shift right that keeps the sign bit, and logical shift right that fills with zero. The controller hands it the second opcode byte with a one-cycle `start`. The unit decodes the operation and the operand, takes the operand from its seven-entry register file or from the memory byte addressed by the H:L pair, writes the shifted byte back to where it came from, and updates the flag byte. A one-cycle `done` marks the end. A register operand costs 8 cycles and a memory operand costs 16.

Opcode values outside the three shift groups produce a one-cycle `illegal` pulse and leave all state untouched. A load port lets the surrounding core place values in the register file while the unit is idle. A read port and the flag output expose the architectural state.

Top module: `shift_exec_unit`

## Requirements
- R1: Opcode bits [7:3] choose the operation: 00100 is shift left, 00101 is arithmetic shift right, and 00111 is logical shift right.
- R2: Opcode bits [2:0] choose the operand: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte at address {H,L}, 7=A. The result goes back to that same operand, and no other register changes.
- R3: Shift left puts 0 in bit 0, drops the old bit 7, and copies the old bit 7 into the carry flag.
- R4: Both right shifts copy the old bit 0 into carry. The arithmetic shift right keeps the old bit 7, and the logical shift right puts 0 in bit 7.
- R5: The flag byte has Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, and bits 3..0 always read 0. On completion, Z is set exactly when the result is 0, and N and H are cleared.
- R6: For a register operand, `done` is high for exactly one cycle, in the 8th cycle counting the cycle in which `start` is sampled as cycle 1. The result and the flags are visible in that same cycle.
- R7: For the memory operand, `mem_re` pulses for one cycle with `mem_addr`={H,L} in the cycle after `start`. Read data is expected one cycle after the request. `mem_we` pulses in cycle 15 with the result and the same address, and `done` follows in cycle 16.
- R8: Any other opcode value (including 0x30..0x37) gives a one-cycle `illegal` in the cycle after `start`, gives no `done`, and leaves registers, flags and memory unchanged.
- R9: A `start` that arrives while an operation is in progress is ignored.
- R10: The load port writes `ld_data` into register `ld_sel` when the unit is idle. It is ignored while an operation is in progress, and it is ignored for code 6.
- R11: A synchronous active-high reset clears all registers, the flags, `done`, `illegal`, `mem_re` and `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `opcode` |
| opcode | input | 8 | Second opcode byte |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register code to load |
| ld_data | input | 8 | Load value |
| rd_sel | input | 3 | Register code to observe |
| rd_data | output | 8 | Register value (0 for code 6) |
| flags | output | 8 | Flag byte |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_re` |
| done | output | 1 | Operation complete, one cycle |
| illegal | output | 1 | Rejected opcode, one cycle |

## Verification
The bench targets the corner cases of the flag rules: a shift whose result is zero while carry is set, and an arithmetic right shift of a negative byte. A design that mixed up the fill bits would leave bit 7 wrong or miss the Z flag. It runs the memory path and counts the cycles to `done` for both operand kinds, so a unit that wrote back late, or wrote to the wrong address, shows up as a latency or content mismatch. It also sends opcodes from the gap group 0x30..0x37, a `start` and loads during a busy operation, and a reset in the middle of a run. A design that decoded too loosely, or that reacted while busy, would corrupt a register that the cycle-by-cycle reference model still holds.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RARI  = 2'd1,
    SH_RLOG  = 2'd2
  } shift_op_e;

  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  localparam logic [2:0] OPND_MEM = 3'd6;
  localparam logic [2:0] OPND_H   = 3'd4;
  localparam logic [2:0] OPND_L   = 3'd5;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       valid,
  output shift_op_e  op,
  output logic [2:0] sel,
  output logic       is_mem
);
  always_comb begin
    valid = 1'b1;
    op    = SH_LEFT;
    unique case (opcode[7:3])
      5'b00100: op = SH_LEFT;
      5'b00101: op = SH_RARI;
      5'b00111: op = SH_RLOG;
      default:  valid = 1'b0;
    endcase
  end

  assign sel    = opcode[2:0];
  assign is_mem = (opcode[2:0] == OPND_MEM);
endmodule

// File: rtl/shift_alu.sv
module shift_alu
  import shift_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_op_e      op,
  input  logic [W-1:0]   val,
  output logic [W-1:0]   res,
  output logic           carry,
  output logic           zero
);
  always_comb begin
    unique case (op)
      SH_LEFT: begin res = {val[W-2:0], 1'b0};   carry = val[W-1]; end
      SH_RARI: begin res = {val[W-1], val[W-1:1]}; carry = val[0]; end
      default: begin res = {1'b0, val[W-1:1]};   carry = val[0]; end
    endcase
  end

  assign zero = (res == '0);
endmodule

// File: rtl/shift_regfile.sv
module shift_regfile
  import shift_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [2:0]   ld_sel,
  input  logic [W-1:0] ld_data,
  input  logic         wb_en,
  input  logic [2:0]   wb_sel,
  input  logic [W-1:0] wb_data,
  input  logic         flg_we,
  input  logic         flg_zero,
  input  logic         flg_carry,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] op_data,
  output logic [2*W-1:0] hl,
  input  logic [2:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic [7:0]   flags
);
  localparam int NREG = 8;

  logic [W-1:0] regs [NREG];
  logic [7:0]   flg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      flg_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (i != int'(OPND_MEM)) begin
          if (wb_en && wb_sel == 3'(i))
            regs[i] <= wb_data;
          else if (ld_en && ld_sel == 3'(i))
            regs[i] <= ld_data;
        end
      end
      if (flg_we) begin
        flg_q <= '0;
        flg_q[FLAG_Z] <= flg_zero;
        flg_q[FLAG_C] <= flg_carry;
      end
    end
  end

  assign op_data = (op_sel == OPND_MEM) ? '0 : regs[op_sel];
  assign rd_data = (rd_sel == OPND_MEM) ? '0 : regs[rd_sel];
  assign hl      = {regs[OPND_H], regs[OPND_L]};
  assign flags   = flg_q;

  // R5
  flag_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    flg_we |=> (flags[3:0] == 4'h0 && !flags[FLAG_N] && !flags[FLAG_H]));
endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import shift_pkg::*;
#(
  parameter int W          = 8,
  parameter int REG_CYCLES = 8,
  parameter int MEM_CYCLES = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [7:0]     opcode,
  input  logic           ld_en,
  input  logic [2:0]     ld_sel,
  input  logic [W-1:0]   ld_data,
  input  logic [2:0]     rd_sel,
  output logic [W-1:0]   rd_data,
  output logic [7:0]     flags,
  output logic [2*W-1:0] mem_addr,
  output logic           mem_re,
  output logic           mem_we,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  output logic           done,
  output logic           illegal
);
  localparam int CW = $clog2(MEM_CYCLES + 1);
  localparam logic [CW-1:0] REG_LAST  = CW'(REG_CYCLES - 1);
  localparam logic [CW-1:0] MEM_LAST  = CW'(MEM_CYCLES - 1);
  localparam logic [CW-1:0] MEM_WRITE = CW'(MEM_CYCLES - 2);
  localparam logic [CW-1:0] MEM_CAPT  = CW'(2);

  logic          dec_valid, dec_mem;
  shift_op_e     dec_op;
  logic [2:0]    dec_sel;

  logic          busy;
  logic [CW-1:0] cnt;
  shift_op_e     op_q;
  logic [2:0]    sel_q;
  logic          mem_q;
  logic [W-1:0]  opnd_q;

  logic [W-1:0]   rf_op;
  logic [2*W-1:0] rf_hl;
  logic [W-1:0]   alu_res;
  logic           alu_c, alu_z;
  logic [CW-1:0]  last;
  logic           finish;

  shift_decode u_dec (
    .opcode (opcode), .valid (dec_valid), .op (dec_op),
    .sel    (dec_sel), .is_mem (dec_mem)
  );

  shift_alu #(.W(W)) u_alu (
    .op (op_q), .val (opnd_q), .res (alu_res), .carry (alu_c), .zero (alu_z)
  );

  assign last   = mem_q ? MEM_LAST : REG_LAST;
  assign finish = busy && (cnt == last);

  shift_regfile #(.W(W)) u_rf (
    .clk (clk), .rst (rst),
    .ld_en (ld_en && !busy), .ld_sel (ld_sel), .ld_data (ld_data),
    .wb_en (finish && !mem_q), .wb_sel (sel_q), .wb_data (alu_res),
    .flg_we (finish), .flg_zero (alu_z), .flg_carry (alu_c),
    .op_sel (dec_sel), .op_data (rf_op), .hl (rf_hl),
    .rd_sel (rd_sel), .rd_data (rd_data), .flags (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      op_q      <= SH_LEFT;
      sel_q     <= '0;
      mem_q     <= 1'b0;
      opnd_q    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      done      <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      mem_re  <= 1'b0;
      mem_we  <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (dec_valid) begin
            busy   <= 1'b1;
            cnt    <= CW'(1);
            op_q   <= dec_op;
            sel_q  <= dec_sel;
            mem_q  <= dec_mem;
            opnd_q <= rf_op;
            if (dec_mem) begin
              mem_addr <= rf_hl;
              mem_re   <= 1'b1;
            end
          end else begin
            illegal <= 1'b1;
          end
        end
      end else begin
        if (mem_q && cnt == MEM_CAPT)
          opnd_q <= mem_rdata;
        if (mem_q && cnt == MEM_WRITE) begin
          mem_we    <= 1'b1;
          mem_wdata <= alu_res;
        end
        if (finish) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  write_before_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> done);
  // R7
  read_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);
  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!done && !busy && $stable(flags)));
  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= last));
endmodule

// File: tb/test_shift_exec_unit.sv
module test_shift_exec_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] opcode = '0;
  logic ld_en = 1'b0;
  logic [2:0] ld_sel = '0;
  logic [7:0] ld_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data, flags, mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic [15:0] mem_addr;
  logic mem_re, mem_we, done, illegal;

  always #10 clk = ~clk;

  shift_exec_unit i_shift_exec_unit (
    .clk (clk), .rst (rst), .start (start), .opcode (opcode),
    .ld_en (ld_en), .ld_sel (ld_sel), .ld_data (ld_data),
    .rd_sel (rd_sel), .rd_data (rd_data), .flags (flags),
    .mem_addr (mem_addr), .mem_re (mem_re), .mem_we (mem_we),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .done (done), .illegal (illegal)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory
  logic [7:0] mem [logic [15:0]];
  function automatic logic [7:0] mrd(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mrd(mem_addr);
    if (mem_we) mem[mem_addr] = mem_wdata;
  end

  // observation select
  logic [2:0] want_sel = '0;
  logic want_on = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_sel <= want_on ? want_sel : 3'(cyc % 8);
  end

  // reference model
  int m_regs [8];
  int m_flags, m_el, m_lat, m_sel, m_res, m_newf, m_hl;
  bit m_busy, m_mem;
  bit e_done, e_ill, e_re, e_we;
  int e_addr, e_wdata;

  always @(posedge clk) begin
    bit was_busy;
    was_busy = m_busy;
    if (rst) begin
      foreach (m_regs[i]) m_regs[i] = 0;
      m_flags = 0; m_busy = 0; m_el = 0;
      e_done = 0; e_ill = 0; e_re = 0; e_we = 0;
    end else begin
      e_done = 0; e_ill = 0; e_re = 0; e_we = 0;
      if (m_busy) begin
        if (m_mem && m_el == 14) begin e_we = 1; e_wdata = m_res; end
        if (m_el == m_lat - 1) begin
          m_busy = 0; e_done = 1; m_flags = m_newf;
          if (!m_mem) m_regs[m_sel] = m_res;
        end else m_el++;
      end else if (start) begin
        int grp, v, c;
        grp = opcode >> 3;
        if (grp != 4 && grp != 5 && grp != 7) e_ill = 1;
        else begin
          m_sel = opcode & 7;
          m_mem = (m_sel == 6);
          m_hl = m_regs[4] * 256 + m_regs[5];
          v = m_mem ? int'(mrd(16'(m_hl))) : m_regs[m_sel];
          if (grp == 4) begin m_res = (v * 2) % 256; c = v / 128; end
          else if (grp == 5) begin m_res = v / 2 + (v / 128) * 128; c = v % 2; end
          else begin m_res = v / 2; c = v % 2; end
          m_newf = (m_res == 0 ? 8'h80 : 0) + (c ? 8'h10 : 0);
          m_busy = 1; m_el = 1; m_lat = m_mem ? 16 : 8;
          if (m_mem) begin e_re = 1; e_addr = m_hl; end
        end
      end
      if (ld_en && !was_busy && ld_sel != 3'd6) m_regs[ld_sel] = ld_data;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 done", done, e_done);
      chk("R8 illegal", illegal, e_ill);
      chk("R7 mem_re", mem_re, e_re);
      chk("R7 mem_we", mem_we, e_we);
      chk("R5 flags", flags, m_flags);
      chk("R2 register", rd_data, rd_sel == 3'd6 ? 0 : m_regs[rd_sel]);
      if (mem_re || mem_we) chk("R7 mem_addr", mem_addr, e_addr);
      if (mem_we) chk("R7 mem_wdata", mem_wdata, e_wdata);
    end
  end

  task automatic load(int s, int v);
    @(negedge clk); ld_en = 1; ld_sel = 3'(s); ld_data = 8'(v);
    @(negedge clk); ld_en = 0;
  endtask

  task automatic peek(int s, output int v);
    want_sel = 3'(s); want_on = 1;
    @(negedge clk); @(negedge clk);
    v = rd_data; want_on = 0;
  endtask

  task automatic exec(int opc, output int lat);
    @(negedge clk); start = 1; opcode = 8'(opc);
    lat = 0;
    do begin
      @(negedge clk); start = 0; lat++;
    end while (!done && lat < 40);
  endtask

  task automatic reg_case(string tag, int opc, int s, int v, int er, int ef);
    int lat, r;
    load(s, v);
    exec(opc, lat);
    chk({tag, " R6 latency"}, lat, 8);
    chk({tag, " R5 flags"}, flags, ef);
    peek(s, r);
    chk({tag, " result"}, r, er);
  endtask

  initial begin
    int lat, r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 flags", flags, 0);
    chk("R11 done", done, 0);
    peek(7, r); chk("R11 reg A", r, 0);

    reg_case("R3 R1 shl B", 8'h20, 0, 8'h81, 8'h02, 8'h10);
    reg_case("R5 shl A zero", 8'h27, 7, 8'h80, 8'h00, 8'h90);
    reg_case("R4 sra C", 8'h29, 1, 8'h81, 8'hC0, 8'h10);
    reg_case("R4 srl D", 8'h3A, 2, 8'h81, 8'h40, 8'h10);
    reg_case("R5 srl E zero", 8'h3B, 3, 8'h01, 8'h00, 8'h90);
    peek(0, r); chk("R2 B untouched", r, 8'h02);

    // R7 memory operand
    load(4, 8'h12); load(5, 8'h34);
    mem[16'h1234] = 8'h96;
    exec(8'h2E, lat);
    chk("R7 latency", lat, 16);
    chk("R7 memory", mrd(16'h1234), 8'hCB);
    chk("R7 R5 flags", flags, 8'h00);

    // R8 illegal
    @(negedge clk); start = 1; opcode = 8'h33;
    @(negedge clk); start = 0;
    chk("R8 pulse", illegal, 1);
    chk("R8 flags held", flags, 8'h00);
    peek(3, r); chk("R8 E held", r, 8'h00);

    // R9, R10: start and load during busy
    load(5, 8'h03);
    @(negedge clk); start = 1; opcode = 8'h25;
    @(negedge clk); start = 0;
    @(negedge clk); start = 1; opcode = 8'h20;
    ld_en = 1; ld_sel = 3'd1; ld_data = 8'h55;
    @(negedge clk); start = 0; ld_en = 0;
    while (!done) @(negedge clk);
    peek(0, r); chk("R9 B unchanged", r, 8'h02);
    peek(1, r); chk("R10 C unchanged", r, 8'hC0);
    peek(5, r); chk("R2 L result", r, 8'h06);
    load(6, 8'hAA);
    peek(6, r); chk("R10 code 6 ignored", r, 0);

    // random mix checked by the model
    for (int k = 0; k < 80; k++) begin
      int opc, sel;
      sel = $urandom % 8;
      if (sel != 6) load(sel, $urandom % 256);
      if ($urandom % 2) mem[{8'(m_regs[4]), 8'(m_regs[5])}] = 8'($urandom);
      case ($urandom % 4)
        0: opc = 8'h20 + $urandom % 8;
        1: opc = 8'h28 + $urandom % 8;
        2: opc = 8'h38 + $urandom % 8;
        default: opc = $urandom % 256;
      endcase
      @(negedge clk); start = 1; opcode = 8'(opc);
      @(negedge clk); start = 0;
      repeat (18) @(negedge clk);
    end

    // R11 reset in mid-run
    @(negedge clk); start = 1; opcode = 8'h3F;
    @(negedge clk); start = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R11 flags after reset", flags, 0);
    chk("R11 done after reset", done, 0);
    peek(4, r); chk("R11 H after reset", r, 0);
    repeat (20) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule